// File: doc/BRIEF.md
# SPDIF Transmit Channel Status Register Bank

This block holds the channel status words that an IEC 60958 transmitter sends, one 40-bit word for the left subframes and one for the right. Software fills a pair of staging words through a byte-wide write port. The encoder never reads the staging words. It reads a second pair of active words, and these are reloaded from staging only at a block boundary, and only while the commit enable input is high. Software can therefore lower commit enable, rewrite any number of bytes and raise it again, and the encoder moves from one consistent set of bits to the next at a block edge.

The framing logic pulses `blk_start` in the cycle before it requests frame 0 of a new 192-frame block. It then presents a frame number on `frame_idx` and reads the left and right status bits for that frame from `cs_left` and `cs_right`, which follow the index combinationally. A mirror input selects whether the right active word is loaded from the right staging word or from the left one. The user bit output is always zero.

A two-state controller gates the loading. `ST_HOLD` (the reset state) moves to `ST_ARMED` on any clock edge at which `commit_enable` is 1. `ST_ARMED` moves back to `ST_HOLD` on any edge at which `commit_enable` is 0. A load happens at an edge where the state is `ST_ARMED`, `blk_start` is 1 and `commit_enable` is 1.

Top module: `spdif_cs_bank`

## Requirements
- R1: After reset, all staging and active status bits are 0, so `cs_left` and `cs_right` read 0 for every frame index.
- R2: Write addresses 0 to 4 load left staging byte k = address, and addresses 5 to 9 load right staging byte k = address − 5. Data bit j of byte k becomes status bit 8k+j. Writes to addresses 10 to 15 change nothing.
- R3: For a frame index f below 40, `cs_left` and `cs_right` give bit f of the left and right active words. For f from 40 to 191, both outputs are 0.
- R4: At a clock edge with state `ST_ARMED`, `blk_start` = 1 and `commit_enable` = 1, the left active word takes the left staging word.
- R5: While `commit_enable` is 0, the active words do not change, so staged writes do not reach the outputs.
- R6: The controller resets to `ST_HOLD` and takes the state named by `commit_enable` at each edge (1 selects `ST_ARMED`, 0 selects `ST_HOLD`). A `blk_start` at the same edge where `commit_enable` first rises does not cause a load. The next block start does.
- R7: At a load, the right active word takes the left staging word when `mirror_left` is 1, and the right staging word when `mirror_left` is 0.
- R8: `user_bit` is 0 at all times.
- R9: The active words change only at an edge where `blk_start` is 1, so they stay constant through a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Staging byte write strobe |
| wr_addr | input | 4 | Staging byte address |
| wr_data | input | 8 | Staging byte value |
| commit_enable | input | 1 | Allows staged words to be loaded at block starts |
| mirror_left | input | 1 | 1: the right channel takes the left staged word at a load |
| blk_start | input | 1 | One-cycle pulse before frame 0 of a block |
| frame_idx | input | 8 | Frame number within the block, 0 to 191 |
| cs_left | output | 1 | Channel status bit for the left subframe of `frame_idx` |
| cs_right | output | 1 | Channel status bit for the right subframe of `frame_idx` |
| user_bit | output | 1 | User bit for both subframes, always 0 |

## Verification
The checks assume that `blk_start` is a single-cycle pulse and that `frame_idx` stays within 0 to 191. They also assume that software changes the mirror selection only outside a load edge, because the right active word is checked against the left staging word only at the edge after a mirrored load. The stimulus follows these rules. Each block is one start pulse followed by a sweep of frames 0 to 191, one frame per cycle. The mirror and enable inputs change only between blocks, except in the one case that deliberately raises `commit_enable` in the same cycle as `blk_start` to exercise the arming delay.

// File: rtl/spdif_cs_pkg.sv
package spdif_cs_pkg;
    localparam int CS_BITS = 40;
    localparam int FRAMES  = 192;

    typedef enum logic [0:0] {
        ST_HOLD  = 1'b0,
        ST_ARMED = 1'b1
    } cs_state_e;
endpackage

// File: rtl/cs_stage_regs.sv
module cs_stage_regs #(
    parameter int CS_BITS = 40,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [7:0]         wr_data,
    output logic [CS_BITS-1:0] stg_l,
    output logic [CS_BITS-1:0] stg_r
);
    localparam int NBYTES = (CS_BITS + 7) / 8;

    logic [NBYTES*8-1:0] pad_l;
    logic [NBYTES*8-1:0] pad_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pad_l <= '0;
            pad_r <= '0;
        end else if (wr_en) begin
            for (int k = 0; k < NBYTES; k++) begin
                if (wr_addr == ADDR_W'(k))
                    pad_l[k*8 +: 8] <= wr_data;
                if (wr_addr == ADDR_W'(NBYTES + k))
                    pad_r[k*8 +: 8] <= wr_data;
            end
        end
    end

    assign stg_l = pad_l[CS_BITS-1:0];
    assign stg_r = pad_r[CS_BITS-1:0];
endmodule

// File: rtl/cs_commit_fsm.sv
module cs_commit_fsm
    import spdif_cs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      commit_enable,
    input  logic      blk_start,
    output cs_state_e state,
    output logic      commit
);
    cs_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HOLD:  if (commit_enable)  state_nx = ST_ARMED;
            ST_ARMED: if (!commit_enable) state_nx = ST_HOLD;
            default:  state_nx = ST_HOLD;
        endcase
    end

    always_comb begin
        commit = 1'b0;
        unique case (state)
            ST_HOLD:  commit = 1'b0;
            ST_ARMED: commit = blk_start & commit_enable;
            default:  commit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cs_active_regs.sv
module cs_active_regs #(
    parameter int CS_BITS = 40,
    parameter int IDX_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic               mirror_left,
    input  logic [CS_BITS-1:0] stg_l,
    input  logic [CS_BITS-1:0] stg_r,
    input  logic [IDX_W-1:0]   frame_idx,
    output logic [CS_BITS-1:0] act_l,
    output logic [CS_BITS-1:0] act_r,
    output logic               cs_left,
    output logic               cs_right
);
    localparam int SEL_W = $clog2(CS_BITS);

    logic             in_head;
    logic [SEL_W-1:0] sel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_l <= '0;
            act_r <= '0;
        end else if (commit) begin
            act_l <= stg_l;
            act_r <= mirror_left ? stg_l : stg_r;
        end
    end

    assign in_head  = (frame_idx < IDX_W'(CS_BITS));
    assign sel      = frame_idx[SEL_W-1:0];
    assign cs_left  = in_head & act_l[sel];
    assign cs_right = in_head & act_r[sel];
endmodule

// File: rtl/spdif_cs_bank.sv
module spdif_cs_bank
    import spdif_cs_pkg::*;
#(
    parameter int CS_W    = spdif_cs_pkg::CS_BITS,
    parameter int NFRAMES = spdif_cs_pkg::FRAMES,
    parameter int ADDR_W  = 4,
    parameter int IDX_W   = $clog2(NFRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              commit_enable,
    input  logic              mirror_left,
    input  logic              blk_start,
    input  logic [IDX_W-1:0]  frame_idx,
    output logic              cs_left,
    output logic              cs_right,
    output logic              user_bit
);
    logic [CS_W-1:0] stg_l, stg_r, act_l, act_r;
    cs_state_e       fsm_state;
    logic            commit;

    cs_stage_regs #(.CS_BITS(CS_W), .ADDR_W(ADDR_W)) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stg_l(stg_l), .stg_r(stg_r)
    );

    cs_commit_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .commit_enable(commit_enable),
        .blk_start(blk_start), .state(fsm_state), .commit(commit)
    );

    cs_active_regs #(.CS_BITS(CS_W), .IDX_W(IDX_W)) u_active (
        .clk(clk), .rst_n(rst_n), .commit(commit), .mirror_left(mirror_left),
        .stg_l(stg_l), .stg_r(stg_r), .frame_idx(frame_idx),
        .act_l(act_l), .act_r(act_r), .cs_left(cs_left), .cs_right(cs_right)
    );

    assign user_bit = 1'b0;
endmodule

// File: rtl/spdif_cs_bank_chk.sv
module spdif_cs_bank_chk
    import spdif_cs_pkg::*;
#(
    parameter int CS_W  = 40,
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             commit_enable,
    input logic             mirror_left,
    input logic             blk_start,
    input logic [IDX_W-1:0] frame_idx,
    input logic             cs_left,
    input logic             cs_right,
    input logic [CS_W-1:0]  stg_l,
    input logic [CS_W-1:0]  act_l,
    input logic [CS_W-1:0]  act_r,
    input cs_state_e        fsm_state
);
    // R3: frames past the status word carry zeros
    a_r3_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_idx >= IDX_W'(CS_W)) |-> (!cs_left && !cs_right));

    // R4: a load copies the left staging word
    a_r4_load_left: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_ARMED && blk_start && commit_enable) |=> (act_l == $past(stg_l)));

    // R5: enable low freezes the active words
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_enable |=> ($stable(act_l) && $stable(act_r)));

    // R6: controller follows the enable input
    a_r6_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_enable |=> (fsm_state == ST_HOLD));
    a_r6_to_armed: assert property (@(posedge clk) disable iff (!rst_n)
        commit_enable |=> (fsm_state == ST_ARMED));

    // R7: mirrored load makes both channels equal
    a_r7_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state == ST_ARMED && blk_start && commit_enable && mirror_left) |=> (act_r == act_l));

    // R9: no change away from a block start
    a_r9_block_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_start |=> ($stable(act_l) && $stable(act_r)));
endmodule

bind spdif_cs_bank spdif_cs_bank_chk #(.CS_W(CS_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .commit_enable(commit_enable),
    .mirror_left(mirror_left), .blk_start(blk_start), .frame_idx(frame_idx),
    .cs_left(cs_left), .cs_right(cs_right), .stg_l(stg_l),
    .act_l(act_l), .act_r(act_r), .fsm_state(fsm_state)
);

// File: tb/sim_spdif_cs_bank.sv
`timescale 1ns/1ps
module sim_spdif_cs_bank;
    localparam int CSB = 40;
    localparam int NF  = 192;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       commit_enable = 1'b0;
    logic       mirror_left = 1'b0;
    logic       blk_start = 1'b0;
    logic [7:0] frame_idx = '0;
    logic       cs_left, cs_right, user_bit;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [CSB-1:0] l;
        logic [CSB-1:0] r;
        string          tag;
    } exp_t;
    exp_t sbq[$];

    // requirement model
    logic [CSB-1:0] m_stg_l = '0, m_stg_r = '0, m_act_l = '0, m_act_r = '0;
    logic           m_armed = 1'b0;
    logic           in_blk = 1'b0;

    always #2 clk = ~clk;

    spdif_cs_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit_enable(commit_enable),
        .mirror_left(mirror_left), .blk_start(blk_start),
        .frame_idx(frame_idx), .cs_left(cs_left), .cs_right(cs_right),
        .user_bit(user_bit)
    );

    // R2, R4, R6, R7 model
    always @(posedge clk) begin
        if (rst_n) begin
            if (blk_start && m_armed && commit_enable) begin
                m_act_l <= m_stg_l;
                m_act_r <= mirror_left ? m_stg_l : m_stg_r;
            end
            m_armed <= commit_enable;
            if (wr_en && wr_addr < 4'd5)
                m_stg_l[wr_addr*8 +: 8] <= wr_data;
            else if (wr_en && wr_addr < 4'd10)
                m_stg_r[(wr_addr-4'd5)*8 +: 8] <= wr_data;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wr_word(input int ch, input logic [CSB-1:0] v);
        for (int k = 0; k < 5; k++) wr(4'(ch*5 + k), v[k*8 +: 8]);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    // driver: one block start then a full frame sweep
    task automatic run_block(input string tag, input bit raise_en);
        exp_t e;
        blk_start = 1'b1;
        if (raise_en) commit_enable = 1'b1;
        @(posedge clk); #1;
        blk_start = 1'b0;
        e.l = m_act_l; e.r = m_act_r; e.tag = tag;
        sbq.push_back(e);
        in_blk = 1'b1;
        for (int f = 0; f < NF; f++) begin
            frame_idx = 8'(f);
            @(posedge clk); #1;
        end
        in_blk = 1'b0;
        frame_idx = '0;
    endtask

    // monitor
    initial begin
        exp_t cur;
        int   bad, ubad;
        logic el, er;
        forever begin
            @(negedge clk);
            if (in_blk) begin
                if (frame_idx == 8'd0) begin
                    cur = sbq.pop_front();
                    bad = 0; ubad = 0;
                end
                el = (frame_idx < 8'(CSB)) ? cur.l[frame_idx[5:0]] : 1'b0;
                er = (frame_idx < 8'(CSB)) ? cur.r[frame_idx[5:0]] : 1'b0;
                if ((cs_left !== el || cs_right !== er) && bad == 0) begin
                    $display("FAIL %s frame %0d: got L=%b R=%b expected L=%b R=%b (R3)",
                             cur.tag, frame_idx, cs_left, cs_right, el, er);
                    bad = 1;
                end
                if (user_bit !== 1'b0 && ubad == 0) begin
                    $display("FAIL R8 %s frame %0d: user_bit=%b expected 0",
                             cur.tag, frame_idx, user_bit);
                    ubad = 1;
                end
                if (frame_idx == 8'(NF-1)) begin
                    checks += 2;
                    errors += bad + ubad;
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk);
        checks++;
        if (cs_left !== 1'b0 || cs_right !== 1'b0 || user_bit !== 1'b0) begin
            errors++;
            $display("FAIL R1 in reset: got %b%b%b expected 000", cs_left, cs_right, user_bit);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(2);

        run_block("R1 defaults", 1'b0);

        wr_word(0, 40'h12_3456_789A);
        wr_word(1, 40'hA5_C3F0_0F5A);
        run_block("R5 staged while disabled", 1'b0);

        commit_enable = 1'b1;
        idle(2);
        run_block("R4 R2 separate load", 1'b0);

        commit_enable = 1'b0;
        idle(1);
        wr_word(0, 40'h80_0000_0001);
        run_block("R5 hold old words", 1'b0);

        for (int a = 10; a < 16; a++) wr(4'(a), 8'hFF);
        commit_enable = 1'b1;
        idle(2);
        run_block("R2 high addresses ignored", 1'b0);

        mirror_left = 1'b1;
        idle(1);
        run_block("R7 mirror left to right", 1'b0);

        mirror_left = 1'b0;
        wr_word(0, {CSB{1'b1}});
        wr_word(1, {CSB{1'b1}});
        run_block("R3 all ones with zero tail", 1'b0);

        commit_enable = 1'b0;
        idle(1);
        wr_word(0, 40'h0F_1E2D_3C4B);
        run_block("R6 enable raised at block start", 1'b1);
        run_block("R6 load at following block", 1'b0);

        run_block("R9 unchanged block", 1'b0);

        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule